// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

A purely combinational block that decides an ordering relation between two binary32 floating-point words. A 3-bit condition selector picks which relation is reported on a single result line: equal, not equal, less than, less or equal, greater than, or greater or equal. A second output shows when the pair cannot be ordered because at least one operand is not a number.

The block does not decode the operands into values. It compares the two words with the sign bit removed, as unsigned integers, and then corrects that result in three ways. The sign bits settle pairs of opposite sign. A negative pair takes the reversed order. A pair of zeros of either sign is forced to equal. NaN operands are detected separately and override everything else. With this encoding, denormals, normalized values and infinities all order correctly through the same unsigned compare. A parameter selects whether the magnitude compare is one wide comparator or a tree of narrow chunk comparators.

Top module: `fp_order_cmp`

## Requirements
- R1: A word whose exponent field (bits 30..23) is all ones and whose fraction field (bits 22..0) is nonzero is a NaN. `unordered` is 1 exactly when either operand is a NaN.
- R2: For two positive non-NaN operands that are not both zero, the order follows the unsigned order of bits 30..0.
- R3: For two negative non-NaN operands that are not both zero, the order is the reverse of the unsigned order of bits 30..0.
- R4: When the sign bits (bit 31) differ and the operands are not both zero, the operand with sign 1 is the smaller one.
- R5: Positive zero and negative zero compare equal in every sign combination.
- R6: Denormals order correctly against normalized values, and finite values order correctly against infinities (exponent all ones, fraction zero), with the sign of the infinity respected.
- R7: When `unordered` is 1, codes 0, 2, 3, 4 and 5 give `result` 0 and code 1 gives `result` 1.
- R8: The `cond` encoding is 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal, each relation read as `op_a` relation `op_b`. Codes 6 and 7 always give `result` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Left operand, binary32 encoding |
| op_b | input | 32 | Right operand, binary32 encoding |
| cond | input | 3 | Relation selector (see R8) |
| result | output | 1 | Value of the selected relation |
| unordered | output | 1 | At least one operand is a NaN |

## Verification
The checker tests the NaN override, the forced zero result of the unused codes, the equal result for any pair of zeros, and the rule that a negative operand is less than a positive one, whenever the inputs settle. The correctness of the magnitude ordering itself, including the reversal for negative pairs and the placement of denormals and infinities, can only be shown by the bench. The bench compares each result against a reference built from real-valued decodes of the operands, over every pairing of a table of boundary encodings and over a long pseudo-random stream.

// File: rtl/fp_order_cmp_pkg.sv
package fp_order_cmp_pkg;
   typedef enum logic [2:0] {
      REL_EQ = 3'd0,
      REL_NE = 3'd1,
      REL_LT = 3'd2,
      REL_LE = 3'd3,
      REL_GT = 3'd4,
      REL_GE = 3'd5
   } rel_code_e;

   typedef struct packed {
      logic sign;
      logic is_nan;
      logic is_zero;
   } op_class_t;
endpackage

// File: rtl/fp_order_classify.sv
module fp_order_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MAG_W  = EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0]              word,
   output fp_order_cmp_pkg::op_class_t    cls,
   output logic [MAG_W-1:0]               mag
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign exp_f  = word[WORD_W-2 -: EXP_W];
   assign frac_f = word[FRAC_W-1:0];
   assign mag    = word[MAG_W-1:0];

   always_comb begin
      cls.sign    = word[WORD_W-1];
      cls.is_nan  = (&exp_f) && (|frac_f);
      cls.is_zero = ~|mag;
   end
endmodule

// File: rtl/fp_order_magcmp.sv
module fp_order_magcmp #(
   parameter int MAG_W   = 31,
   parameter int CHUNK_W = 0,
   localparam int NCH    = (CHUNK_W > 0) ? (MAG_W + CHUNK_W - 1) / CHUNK_W : 1,
   localparam int PAD_W  = (CHUNK_W > 0) ? NCH * CHUNK_W : MAG_W
) (
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             a_lt,
   output logic             a_eq
);
   generate
      if (CHUNK_W == 0) begin : g_flat
         assign a_lt = mag_a < mag_b;
         assign a_eq = mag_a == mag_b;
      end else begin : g_tree
         logic [PAD_W-1:0] pa, pb;
         logic [NCH-1:0]   c_lt, c_eq;
         assign pa = PAD_W'(mag_a);
         assign pb = PAD_W'(mag_b);
         for (genvar k = 0; k < NCH; k++) begin : g_chunk
            assign c_lt[k] = pa[k*CHUNK_W +: CHUNK_W] < pb[k*CHUNK_W +: CHUNK_W];
            assign c_eq[k] = pa[k*CHUNK_W +: CHUNK_W] == pb[k*CHUNK_W +: CHUNK_W];
         end
         always_comb begin
            logic lt_acc, eq_acc;
            lt_acc = 1'b0;
            eq_acc = 1'b1;
            for (int k = NCH - 1; k >= 0; k--) begin
               lt_acc = lt_acc | (eq_acc & c_lt[k]);
               eq_acc = eq_acc & c_eq[k];
            end
            a_lt = lt_acc;
            a_eq = eq_acc;
         end
      end
   endgenerate
endmodule

// File: rtl/fp_order_relsel.sv
module fp_order_relsel (
   input  fp_order_cmp_pkg::op_class_t ca,
   input  fp_order_cmp_pkg::op_class_t cb,
   input  logic       mag_lt,
   input  logic       mag_eq,
   input  logic [2:0] cond,
   output logic       result,
   output logic       unordered
);
   import fp_order_cmp_pkg::*;
   logic rel_eq, rel_lt, rel_gt, both_zero;

   always_comb begin
      unordered = ca.is_nan | cb.is_nan;
      both_zero = ca.is_zero & cb.is_zero;
      rel_eq = 1'b0;
      rel_lt = 1'b0;
      if (!unordered) begin
         if (both_zero) begin
            rel_eq = 1'b1;
         end else if (ca.sign != cb.sign) begin
            rel_lt = ca.sign;
         end else begin
            rel_eq = mag_eq;
            rel_lt = ca.sign ? (!mag_lt && !mag_eq) : mag_lt;
         end
      end
      rel_gt = !unordered && !rel_eq && !rel_lt;
      unique case (cond)
         REL_EQ:  result = rel_eq;
         REL_NE:  result = !rel_eq;
         REL_LT:  result = rel_lt;
         REL_LE:  result = rel_lt | rel_eq;
         REL_GT:  result = rel_gt;
         REL_GE:  result = rel_gt | rel_eq;
         default: result = 1'b0;
      endcase
   end
endmodule

// File: rtl/fp_order_cmp.sv
module fp_order_cmp #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int CHUNK_W = 8,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MAG_W  = EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [2:0]        cond,
   output logic              result,
   output logic              unordered
);
   generate
      if (EXP_W < 2)               begin : g_bad_exp   $error("EXP_W must be at least 2"); end
      if (FRAC_W < 1)              begin : g_bad_frac  $error("FRAC_W must be at least 1"); end
      if (CHUNK_W < 0 || CHUNK_W > MAG_W) begin : g_bad_chunk $error("CHUNK_W out of range"); end
   endgenerate

   fp_order_cmp_pkg::op_class_t cls_a, cls_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic m_lt, m_eq;

   fp_order_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
      .word(op_a), .cls(cls_a), .mag(mag_a));
   fp_order_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
      .word(op_b), .cls(cls_b), .mag(mag_b));

   fp_order_magcmp #(.MAG_W(MAG_W), .CHUNK_W(CHUNK_W)) u_mag (
      .mag_a(mag_a), .mag_b(mag_b), .a_lt(m_lt), .a_eq(m_eq));

   fp_order_relsel u_sel (
      .ca(cls_a), .cb(cls_b), .mag_lt(m_lt), .mag_eq(m_eq),
      .cond(cond), .result(result), .unordered(unordered));
endmodule

// File: rtl/fp_order_cmp_chk.sv
module fp_order_cmp_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic [2:0]        cond,
   input logic              result,
   input logic              unordered
);
   logic nan_a, nan_b, zero_a, zero_b;
   assign nan_a  = (&op_a[WORD_W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
   assign nan_b  = (&op_b[WORD_W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
   assign zero_a = ~|op_a[WORD_W-2:0];
   assign zero_b = ~|op_b[WORD_W-2:0];

   always_comb begin
      if (!$isunknown({op_a, op_b, cond})) begin
         // R1
         nan_flag_chk: assert (unordered == (nan_a | nan_b));
         // R7
         nan_override_chk: assert (!(nan_a | nan_b) || (result == (cond == 3'd1)));
         // R8
         spare_code_chk: assert (cond < 3'd6 || result == 1'b0);
         // R5
         zero_equal_chk: assert (!(zero_a && zero_b && cond == 3'd0) || result);
         // R4
         sign_order_chk: assert (!(cond == 3'd2 && op_a[WORD_W-1] != op_b[WORD_W-1]
                                   && !(zero_a && zero_b) && !nan_a && !nan_b)
                                 || result == op_a[WORD_W-1]);
      end
   end
endmodule

bind fp_order_cmp fp_order_cmp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .op_a(op_a), .op_b(op_b), .cond(cond), .result(result), .unordered(unordered));

// File: tb/sim_fp_order_cmp.sv
module sim_fp_order_cmp;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [2:0]  cond = '0;
   logic        result, unordered;
   int n_run = 0, n_fail = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;

   fp_order_cmp u0 (.op_a(op_a), .op_b(op_b), .cond(cond),
                    .result(result), .unordered(unordered));

   function automatic bit is_nan(logic [31:0] w);
      return (w[30:23] == 8'hFF) && (w[22:0] != 0);
   endfunction

   function automatic real fval(logic [31:0] w);
      real v;
      int  e;
      e = int'(w[30:23]);
      if (e == 255)    v = 1.0e300;
      else if (e == 0) v = real'(w[22:0]) * (2.0 ** (-149.0));
      else             v = (8388608.0 + real'(w[22:0])) * (2.0 ** $itor(e - 150));
      return w[31] ? -v : v;
   endfunction

   function automatic bit ref_rel(logic [31:0] a, logic [31:0] b, logic [2:0] c);
      real x, y;
      if (is_nan(a) || is_nan(b)) return (c == 3'd1);
      x = fval(a); y = fval(b);
      case (c)
         3'd0: return x == y;
         3'd1: return x != y;
         3'd2: return x < y;
         3'd3: return x <= y;
         3'd4: return x > y;
         3'd5: return x >= y;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit odd_class(logic [31:0] w);
      return (w[30:23] == 8'h00 && w[22:0] != 0) || (w[30:23] == 8'hFF);
   endfunction

   function automatic string tag_of(logic [31:0] a, logic [31:0] b, logic [2:0] c);
      if (is_nan(a) || is_nan(b))              return "R7";
      if (c >= 3'd6)                           return "R8";
      if (a[30:0] == 0 && b[30:0] == 0)        return "R5";
      if (odd_class(a) || odd_class(b))        return "R6";
      if (a[31] != b[31])                      return "R4";
      if (a[31])                               return "R3";
      return "R2";
   endfunction

   task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] c);
      bit exp_r, exp_u;
      @(negedge clk);
      op_a = a; op_b = b; cond = c;
      @(posedge clk); #1;
      exp_r = ref_rel(a, b, c);
      exp_u = is_nan(a) || is_nan(b);
      n_run++;
      if (result !== exp_r) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h cond=%0d result=%b expected=%b",
                  tag_of(a, b, c), a, b, c, result, exp_r);
      end
      n_run++;
      if (unordered !== exp_u) begin
         n_fail++;
         $display("FAIL R1 a=%h b=%h unordered=%b expected=%b", a, b, unordered, exp_u);
      end
   endtask

   logic [31:0] table_v [24];
   initial begin
      table_v[0]  = 32'h0000_0000; table_v[1]  = 32'h8000_0000;
      table_v[2]  = 32'h0000_0001; table_v[3]  = 32'h8000_0001;
      table_v[4]  = 32'h007F_FFFF; table_v[5]  = 32'h807F_FFFF;
      table_v[6]  = 32'h0080_0000; table_v[7]  = 32'h8080_0000;
      table_v[8]  = 32'h3F80_0000; table_v[9]  = 32'hBF80_0000;
      table_v[10] = 32'h3FC0_0000; table_v[11] = 32'hBFC0_0000;
      table_v[12] = 32'h7F7F_FFFF; table_v[13] = 32'hFF7F_FFFF;
      table_v[14] = 32'h7F80_0000; table_v[15] = 32'hFF80_0000;
      table_v[16] = 32'h7FC0_0000; table_v[17] = 32'hFFC0_0000;
      table_v[18] = 32'h7F80_0001; table_v[19] = 32'h3F80_0001;
      table_v[20] = 32'hC126_0000; table_v[21] = 32'h4194_0000;
      table_v[22] = 32'h3D80_0000; table_v[23] = 32'h7FFF_FFFF;
   end

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [31:0] lfsr;
      logic [31:0] ra, rb;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Initial state: both +0 with equal selected -> 1 (R5)
      #1;
      n_run++;
      if (result !== 1'b1 || unordered !== 1'b0) begin
         n_fail++;
         $display("FAIL R5 initial result=%b unordered=%b expected=1/0", result, unordered);
      end
      // Boundary table: every pairing under every code (R1..R8)
      for (int i = 0; i < 24; i++)
         for (int j = 0; j < 24; j++)
            for (int c = 0; c < 8; c++)
               apply(table_v[i], table_v[j], 3'(c));
      // Pseudo-random stream, with near pairs to exercise close magnitudes (R2, R3)
      lfsr = 32'hACE1_2468;
      for (int k = 0; k < 1800; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         ra = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         rb = (k % 3 == 0) ? (ra ^ {lfsr[31], 23'd0, lfsr[7:0]}) : lfsr;
         apply(ra, rb, 3'(k % 8));
         apply(rb, ra, 3'((k + 3) % 8));
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule